// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a two-port 16K x 8 memory and watches the requests of both ports. When both ports are selected at the same location, one port is told that the location is busy and its writes are held back, while the other proceeds. The decision uses only the chip selects and the addresses. Whether the access is a read or a write plays no part.

A role select input picks between deciding and following. In deciding (master) mode, the block tracks which port's request was steady first. That port wins. A port that arrives in the same cycle as the other loses to the left port. The block keeps the winner in a register while the winning port stays where it is, so the grant does not move. In following (slave) mode, the block makes no decision of its own. Its busy outputs rest high, and two per-port busy inputs do nothing except stop that port's writes. This lets several copies of the block guard a wider word under a single decision.

All logic runs on one clock with a synchronous active-high reset. The busy flags come from a register. The write-enable gates are combinational, so a losing write is stopped in the cycle it is presented.

Top module: `dp_busy_arbiter`

## Requirements
- R1: After reset, both busy outputs are high (1 = free, 0 = busy) and both ports may write.
- R2: When either chip select is high (inactive) or the two addresses differ, both busy outputs are high one clock later.
- R3: When one port's request (select low, same address) was already present in the previous cycle and the other port newly arrives at that address, the newly arriving port sees its busy output low one clock later.
- R4: When both ports arrive at the same address in the same cycle, the right port loses: right busy goes low one clock later and left busy stays high.
- R5: The two busy outputs are never low at the same time.
- R6: The read/write strobes (0 = write) have no effect on either busy output.
- R7: In master mode, a write from the port that is losing the collision in the current cycle is blocked in that same cycle, and the winner's write passes.
- R8: The losing port's busy output returns high in the clock after the address match ends or either chip select goes high.
- R9: While both ports stay selected at the same address with unchanged requests, the grant stays with the port that first held it.
- R10: With the role select low (slave), both busy outputs are high, and a low busy input on a port blocks that port's writes.
- R11: With the role select high (master), the busy inputs have no effect.
- R12: A port's write enable is high only while its chip select and read/write strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_sel | input | 1 | 1 = decide and drive busy, 0 = follow the busy inputs |
| l_addr | input | 14 | Left port address |
| l_ce_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left read/write strobe, 0 = write |
| l_busy_in_n | input | 1 | Left write-inhibit input, used in slave mode, active low |
| r_addr | input | 14 | Right port address |
| r_ce_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right read/write strobe, 0 = write |
| r_busy_in_n | input | 1 | Right write-inhibit input, used in slave mode, active low |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_en | output | 1 | Left write allowed to reach the array |
| r_wr_en | output | 1 | Right write allowed to reach the array |

## Verification
The busy flags change one clock after the request pattern that causes them, both when set and when released. The write-enable gates follow the current inputs in the same cycle. The bench drives new inputs just after a falling edge. One time unit later it compares the write gates against a model that uses those inputs, and the busy flags against the model's registered owner. It then advances the model across the rising edge. Scenario checks that call out R3, R4 and R8 are read only after that edge has been crossed, so each looks at the cycle in which its result is due.

// File: rtl/dpba_pkg.sv
package dpba_pkg;

    localparam int DPBA_ADDR_W = 14;
    localparam int DPBA_PORTS  = 2;
    localparam int DPBA_LEFT   = 0;
    localparam int DPBA_RIGHT  = 1;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // per-port request summary handed to the collision logic
    typedef struct packed {
        logic active;   // chip select low this cycle
        logic settled;  // same address and select also held last cycle
    } req_flags_t;

    // the port that settled first takes the location; ties go left
    function automatic owner_e first_settled(req_flags_t fl, req_flags_t fr);
        if (fr.settled && !fl.settled) return OWN_RIGHT;
        return OWN_LEFT;
    endfunction

    // true when port p is on the losing side of owner o
    function automatic logic is_loser(owner_e o, int p);
        if (p == DPBA_LEFT) return o == OWN_RIGHT;
        return o == OWN_LEFT;
    endfunction

endpackage

// File: rtl/dpba_req_track.sv
module dpba_req_track
    import dpba_pkg::*;
#(
    parameter int ADDR_W = DPBA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    output req_flags_t        flags
);
    logic              prev_active;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_active <= 1'b0;
            prev_addr   <= '0;
        end else begin
            prev_active <= !ce_n;
            prev_addr   <= addr;
        end
    end

    always_comb begin
        flags.active  = !ce_n;
        flags.settled = !ce_n && prev_active && (prev_addr == addr);
    end

endmodule

// File: rtl/dpba_collide.sv
module dpba_collide
    import dpba_pkg::*;
#(
    parameter int ADDR_W = DPBA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              decide,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  req_flags_t        fl,
    input  req_flags_t        fr,
    output owner_e            owner_q,
    output owner_e            owner_d
);
    logic hit;

    always_comb begin
        hit = decide && fl.active && fr.active && (addr_l == addr_r);
        if (!hit)
            owner_d = OWN_NONE;
        else if (owner_q == OWN_LEFT && fl.settled)
            owner_d = OWN_LEFT;
        else if (owner_q == OWN_RIGHT && fr.settled)
            owner_d = OWN_RIGHT;
        else
            owner_d = first_settled(fl, fr);
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_NONE;
        else     owner_q <= owner_d;
    end

endmodule

// File: rtl/dpba_wr_gate.sv
module dpba_wr_gate (
    input  logic decide,
    input  logic ce_n,
    input  logic we_n,
    input  logic busy_in_n,
    input  logic lose_now,
    output logic wr_en
);
    logic blocked;

    always_comb begin
        blocked = decide ? lose_now : !busy_in_n;
        wr_en   = !ce_n && !we_n && !blocked;
    end

endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
    import dpba_pkg::*;
#(
    parameter int ADDR_W = DPBA_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_sel,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic              l_busy_in_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_en,
    output logic              r_wr_en
);
    localparam int NP = DPBA_PORTS;

    logic [ADDR_W-1:0] addr_a  [NP];
    logic              ce_a    [NP];
    logic              we_a    [NP];
    logic              bin_a   [NP];
    req_flags_t        flags_a [NP];
    logic              wr_a    [NP];
    logic              busy_a  [NP];
    owner_e            owner_q;
    owner_e            owner_d;

    always_comb begin
        addr_a[DPBA_LEFT]  = l_addr;
        addr_a[DPBA_RIGHT] = r_addr;
        ce_a[DPBA_LEFT]    = l_ce_n;
        ce_a[DPBA_RIGHT]   = r_ce_n;
        we_a[DPBA_LEFT]    = l_we_n;
        we_a[DPBA_RIGHT]   = r_we_n;
        bin_a[DPBA_LEFT]   = l_busy_in_n;
        bin_a[DPBA_RIGHT]  = r_busy_in_n;
    end

    dpba_collide #(.ADDR_W(ADDR_W)) u_collide (
        .clk     (clk),
        .rst     (rst),
        .decide  (master_sel),
        .addr_l  (addr_a[DPBA_LEFT]),
        .addr_r  (addr_a[DPBA_RIGHT]),
        .fl      (flags_a[DPBA_LEFT]),
        .fr      (flags_a[DPBA_RIGHT]),
        .owner_q (owner_q),
        .owner_d (owner_d)
    );

    for (genvar p = 0; p < NP; p++) begin : g_port
        dpba_req_track #(.ADDR_W(ADDR_W)) u_track (
            .clk   (clk),
            .rst   (rst),
            .addr  (addr_a[p]),
            .ce_n  (ce_a[p]),
            .flags (flags_a[p])
        );

        dpba_wr_gate u_gate (
            .decide    (master_sel),
            .ce_n      (ce_a[p]),
            .we_n      (we_a[p]),
            .busy_in_n (bin_a[p]),
            .lose_now  (is_loser(owner_d, p)),
            .wr_en     (wr_a[p])
        );

        // registered loss, shown only while this copy is deciding
        always_comb busy_a[p] = !(master_sel && is_loser(owner_q, p));
    end

    assign l_busy_n = busy_a[DPBA_LEFT];
    assign r_busy_n = busy_a[DPBA_RIGHT];
    assign l_wr_en  = wr_a[DPBA_LEFT];
    assign r_wr_en  = wr_a[DPBA_RIGHT];

endmodule

// File: rtl/dpba_checker.sv
module dpba_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              master_sel,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_ce_n,
    input logic              l_we_n,
    input logic              l_busy_in_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_ce_n,
    input logic              r_we_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_en,
    input logic              r_wr_en
);
    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= !rst;

    logic same_req;
    always_comb same_req = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n)); // R5

    AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (l_ce_n || r_ce_n || (l_addr != r_addr)) |=> (l_busy_n && r_busy_n)); // R2

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !master_sel |-> (l_busy_n && r_busy_n)); // R10

    AST_SLAVE_INHIBIT_L: assert property (@(posedge clk) disable iff (rst)
        (!master_sel && !l_busy_in_n) |-> !l_wr_en); // R10

    AST_WR_NEEDS_STROBE_L: assert property (@(posedge clk) disable iff (rst)
        l_wr_en |-> (!l_ce_n && !l_we_n)); // R12

    AST_WR_NEEDS_STROBE_R: assert property (@(posedge clk) disable iff (rst)
        r_wr_en |-> (!r_ce_n && !r_we_n)); // R12

    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (master_sel && !r_busy_n && same_req && $stable(l_addr) && $stable(r_addr)
         && $stable(l_ce_n) && $stable(r_ce_n) && $past(master_sel))
        |=> (!r_busy_n || !master_sel)); // R9

    AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (master_sel && !r_busy_n && same_req && $stable(l_addr) && $stable(r_addr)
         && $stable(l_ce_n) && $stable(r_ce_n)) |-> !r_wr_en); // R7

endmodule

bind dp_busy_arbiter dpba_checker #(.ADDR_W(ADDR_W)) u_dpba_checker (
    .clk(clk), .rst(rst), .master_sel(master_sel),
    .l_addr(l_addr), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
    .r_addr(r_addr), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
);

// File: tb/dp_busy_arbiter_bench.sv
module dp_busy_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_sel = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_ce_n = 1'b1, l_we_n = 1'b1, l_busy_in_n = 1'b1;
    logic r_ce_n = 1'b1, r_we_n = 1'b1, r_busy_in_n = 1'b1;
    logic l_busy_n, r_busy_n, l_wr_en, r_wr_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // reference state: 0 none, 1 left holds, 2 right holds
    int m_own = 0;
    bit m_pl_en = 0, m_pr_en = 0;
    int m_pl_addr = 0, m_pr_addr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_busy_arbiter u_dp_busy_arbiter (
        .clk(clk), .rst(rst), .master_sel(master_sel),
        .l_addr(l_addr), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_busy_in_n(l_busy_in_n),
        .r_addr(r_addr), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n), .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
    );

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: compare against the model, then cross the rising edge
    task automatic tick();
        bit len, ren, hit, lst, rsto, blk_l, blk_r;
        int nxt;
        #1;
        len  = !l_ce_n;
        ren  = !r_ce_n;
        hit  = master_sel && len && ren && (l_addr == r_addr);
        lst  = len && m_pl_en && (int'(l_addr) == m_pl_addr);
        rsto = ren && m_pr_en && (int'(r_addr) == m_pr_addr);
        if (!hit) nxt = 0;
        else if (m_own == 1 && lst) nxt = 1;
        else if (m_own == 2 && rsto) nxt = 2;
        else if (rsto && !lst) nxt = 2;
        else nxt = 1;
        blk_l = master_sel ? (nxt == 2) : !l_busy_in_n;
        blk_r = master_sel ? (nxt == 1) : !r_busy_in_n;
        chk(cur_tag, "l_busy_n", l_busy_n, !(master_sel && m_own == 2));
        chk(cur_tag, "r_busy_n", r_busy_n, !(master_sel && m_own == 1));
        chk(cur_tag, "l_wr_en", l_wr_en, len && !l_we_n && !blk_l);
        chk(cur_tag, "r_wr_en", r_wr_en, ren && !r_we_n && !blk_r);
        @(posedge clk);
        m_own = nxt;
        m_pl_en = len; m_pl_addr = int'(l_addr);
        m_pr_en = ren; m_pr_addr = int'(r_addr);
        @(negedge clk);
    endtask

    task automatic drive_l(bit en, int a, bit wr);
        l_ce_n = !en; l_addr = AW'(a); l_we_n = !wr;
    endtask
    task automatic drive_r(bit en, int a, bit wr);
        r_ce_n = !en; r_addr = AW'(a); r_we_n = !wr;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1: state right after reset
        #1;
        chk("R1", "l_busy_n", l_busy_n, 1'b1);
        chk("R1", "r_busy_n", r_busy_n, 1'b1);
        @(negedge clk);

        // R2: different addresses, both writing
        cur_tag = "R2";
        drive_l(1, 16'h0010, 1); drive_r(1, 16'h0011, 1);
        repeat (3) tick();
        drive_l(1, 16'h0020, 1); drive_r(0, 16'h0020, 1);
        repeat (2) tick();

        // R3: left settles first, right arrives and loses
        cur_tag = "R3";
        drive_l(0, 0, 0); drive_r(0, 0, 0); tick();
        drive_l(1, 16'h0005, 0); tick();
        drive_r(1, 16'h0005, 1); tick();
        chk("R3", "r_busy_n after late arrival", r_busy_n, 1'b0);
        chk("R3", "l_busy_n", l_busy_n, 1'b1);
        // R9: hold, left now writes, grant stays left
        cur_tag = "R9";
        drive_l(1, 16'h0005, 1);
        repeat (3) tick();
        chk("R9", "r_busy_n while left stays", r_busy_n, 1'b0);
        // R8: left deselects, right released one clock later
        cur_tag = "R8";
        drive_l(0, 16'h0005, 0); tick();
        chk("R8", "r_busy_n after release", r_busy_n, 1'b1);
        drive_r(0, 0, 0); tick();

        // R3: right settles first, left arrives and loses (R7 write blocked)
        cur_tag = "R7";
        drive_r(1, 16'h3FFE, 0); tick();
        drive_l(1, 16'h3FFE, 1); tick();
        chk("R3", "l_busy_n after late arrival", l_busy_n, 1'b0);
        chk("R7", "l_wr_en of loser", l_wr_en, 1'b0);
        drive_r(1, 16'h3FFE, 1); tick();
        chk("R7", "r_wr_en of winner", r_wr_en, 1'b1);
        // R8: address mismatch ends the collision
        cur_tag = "R8";
        drive_l(1, 16'h3FFD, 1); tick();
        chk("R8", "l_busy_n after mismatch", l_busy_n, 1'b1);
        drive_l(0, 0, 0); drive_r(0, 0, 0); tick();

        // R4: same-cycle arrival goes left, with reads (R6)
        cur_tag = "R4";
        drive_l(1, 16'h0100, 0); drive_r(1, 16'h0100, 0); tick();
        chk("R4", "r_busy_n on tie", r_busy_n, 1'b0);
        chk("R4", "l_busy_n on tie", l_busy_n, 1'b1);
        // R6: strobes toggled, busy unchanged
        cur_tag = "R6";
        drive_l(1, 16'h0100, 1); drive_r(1, 16'h0100, 1); tick();
        chk("R6", "r_busy_n with writes", r_busy_n, 1'b0);
        drive_l(1, 16'h0100, 0); drive_r(1, 16'h0100, 0); tick();
        drive_l(0, 0, 0); drive_r(0, 0, 0); tick();
        // R4 tie with writes
        cur_tag = "R4";
        drive_l(1, 16'h3FFF, 1); drive_r(1, 16'h3FFF, 1);
        repeat (2) tick();
        // R9: left moves away and right stays: grant cannot be stolen back
        cur_tag = "R9";
        drive_l(1, 16'h0001, 1); tick();
        drive_l(1, 16'h3FFF, 1); tick();
        chk("R9", "l_busy_n after left returns late", l_busy_n, 1'b0);
        drive_l(0, 0, 0); drive_r(0, 0, 0); tick(); tick();

        // R11: busy inputs ignored while deciding
        cur_tag = "R11";
        l_busy_in_n = 0; r_busy_in_n = 0;
        drive_l(1, 16'h0200, 1); drive_r(1, 16'h0201, 1); tick();
        chk("R11", "l_wr_en with input low", l_wr_en, 1'b1);
        tick();

        // R10: slave mode, busy pins act only as write inhibit
        cur_tag = "R10";
        master_sel = 0;
        drive_l(1, 16'h0300, 1); drive_r(1, 16'h0300, 1);
        l_busy_in_n = 1; r_busy_in_n = 1; tick();
        chk("R10", "l_wr_en both inputs high", l_wr_en, 1'b1);
        chk("R10", "r_wr_en both inputs high", r_wr_en, 1'b1);
        l_busy_in_n = 0; tick();
        chk("R10", "l_wr_en inhibited", l_wr_en, 1'b0);
        chk("R10", "l_busy_n stays high", l_busy_n, 1'b1);
        l_busy_in_n = 1; r_busy_in_n = 0; tick(); tick();
        r_busy_in_n = 1;

        // R12: strobe without select, select without strobe
        cur_tag = "R12";
        master_sel = 1;
        drive_l(0, 16'h0400, 1); drive_r(1, 16'h0401, 0); tick();
        chk("R12", "l_wr_en without select", l_wr_en, 1'b0);
        chk("R12", "r_wr_en read only", r_wr_en, 1'b0);
        tick();

        // R5: sweep of patterns, compared every cycle
        cur_tag = "R5";
        for (int i = 0; i < 64; i++) begin
            drive_l(((i * 7) % 5) != 0, (i * 3) % 4, (i % 3) == 0);
            drive_r(((i * 11) % 7) != 0, (i * 5) % 4, (i % 2) == 0);
            master_sel = (i % 13) != 12;
            l_busy_in_n = (i % 6) != 0;
            r_busy_in_n = (i % 9) != 0;
            tick();
            if (i % 4 == 3) tick();
            chk("R5", "busy pair never both low", !(!l_busy_n && !r_busy_n), 1'b1);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule